// File: doc/BRIEF.md
# Dual-Strobe Cascadable Up/Down Counter

A small binary counter that goes up or down by one depending on which of two count strobes rises. One strobe line requests an increment and the other a decrement. The idle level of both lines is high. The block runs on a free-running system clock. Each strobe passes through a synchronizer, and a rising edge found after synchronization issues one count step. An active-high clear and an active-low parallel preset act at their input levels. They are sampled on the system clock, and both take priority over counting.

Two active-low outputs, carry and borrow, make chaining possible without extra gates. Carry is low while the count is at its top value and the up strobe is low. Borrow is low while the count is zero and the down strobe is low. When the strobe returns high, that output rises. Wiring carry into the up strobe of the next stage, and borrow into its down strobe, gives a wider counter. A strobe that rises while the other line is low is treated as a protocol violation, and so is a rise on both lines in the same cycle. In either case the count is held and a one-cycle error flag is raised.

Top module: `updn_cascade_counter`

## Requirements
- R1: While `clr` is sampled high on a clock edge, `q` is zero after that edge. Clear overrides preset, data and both strobes.
- R2: While `load_n` is sampled low and `clr` is low, `q` takes the value of `din` on that edge. Strobe edges that arrive while the preset is held are dropped and never counted later.
- R3: A rising edge on `up_strobe` while `dn_strobe` is high increments `q` by one.
- R4: A rising edge on `dn_strobe` while `up_strobe` is high decrements `q` by one.
- R5: Counting wraps in both directions: up from all-ones to zero, and down from zero to all-ones.
- R6: `carry_n` is 0 exactly when `q` is all-ones and the synchronized `up_strobe` is low. Otherwise it is 1.
- R7: `borrow_n` is 0 exactly when `q` is zero and the synchronized `dn_strobe` is low. Otherwise it is 1.
- R8: A strobe edge while the other strobe is low, or rising edges on both strobes in the same cycle, leaves `q` unchanged. It also raises `proto_err` for exactly one cycle, unless clear or preset is active.
- R9: A strobe edge driven between clock edges changes `q` on the third rising clock edge after it (default of two synchronizer stages).
- R10: When two counters are chained, with `carry_n` driving the next `up_strobe` and `borrow_n` driving the next `dn_strobe`, they count as one wider binary counter across rollovers in both directions.
- R11: After reset, `q` is zero, `carry_n` and `borrow_n` are 1, and `proto_err` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Active-high clear |
| load_n | input | 1 | Active-low parallel preset |
| din | input | WIDTH | Preset value |
| up_strobe | input | 1 | Count-up strobe, acts on its rising edge, idle high |
| dn_strobe | input | 1 | Count-down strobe, acts on its rising edge, idle high |
| q | output | WIDTH | Current count |
| carry_n | output | 1 | Active-low carry for the next stage |
| borrow_n | output | 1 | Active-low borrow for the next stage |
| proto_err | output | 1 | One-cycle pulse on a rejected strobe edge |

## Verification
A wrong count register shows at `q` on the same edge the bad step happens. Through the carry and borrow gating, it also shows one stage later in a cascade. A fault in the synchronizer or the edge detector shows as a step that comes one cycle early or late, as a step missed or doubled, or as a `proto_err` pulse the stimulus did not call for. All of these are visible within a few cycles of the strobe edge. A wrong carry or borrow term is caught directly as an output level while the strobe is held low at the end values. It is caught again as a wrong upper byte after the chained rollovers.

// File: rtl/udc_pkg.sv
package udc_pkg;
  typedef enum logic [2:0] {
    OP_HOLD = 3'd0,
    OP_CLR  = 3'd1,
    OP_LOAD = 3'd2,
    OP_INC  = 3'd3,
    OP_DEC  = 3'd4
  } cnt_op_e;
endpackage

// File: rtl/udc_strobe_sync.sv
module udc_strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic lvl,
  output logic rise
);
  localparam int LAST = STAGES - 1;

  // Shift chain with one extra flop that holds the previous synchronized level.
  // It resets to 1, the idle level of a strobe, so reset never produces an edge.
  logic [STAGES:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-1:0], raw};
  end

  assign lvl  = chain[LAST];
  assign rise = chain[LAST] & ~chain[STAGES];

  p_rise_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/udc_ctrl.sv
module udc_ctrl
  import udc_pkg::*;
(
  input  logic    clr,
  input  logic    load_n,
  input  logic    up_lvl,
  input  logic    dn_lvl,
  input  logic    up_rise,
  input  logic    dn_rise,
  output cnt_op_e op,
  output logic    err_evt
);
  logic bad_edge;

  // An edge is rejected if both strobes rise together or the other line is low.
  assign bad_edge = (up_rise & dn_rise) | (up_rise & ~dn_lvl) | (dn_rise & ~up_lvl);
  assign err_evt  = bad_edge & ~clr & load_n;

  always_comb begin
    if (clr)           op = OP_CLR;
    else if (!load_n)  op = OP_LOAD;
    else if (bad_edge) op = OP_HOLD;
    else if (up_rise)  op = OP_INC;
    else if (dn_rise)  op = OP_DEC;
    else               op = OP_HOLD;
  end
endmodule

// File: rtl/udc_core.sv
module udc_core
  import udc_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  cnt_op_e          op,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] q,
  output logic             at_top,
  output logic             at_bottom
);
  localparam logic [WIDTH-1:0] TOP = '1;

  function automatic logic [WIDTH-1:0] step_up(input logic [WIDTH-1:0] v);
    return (v == TOP) ? '0 : v + WIDTH'(1);
  endfunction

  function automatic logic [WIDTH-1:0] step_dn(input logic [WIDTH-1:0] v);
    return (v == '0) ? TOP : v - WIDTH'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else begin
      unique case (op)
        OP_CLR:  q <= '0;
        OP_LOAD: q <= din;
        OP_INC:  q <= step_up(q);
        OP_DEC:  q <= step_dn(q);
        default: q <= q;
      endcase
    end
  end

  assign at_top    = (q == TOP);
  assign at_bottom = (q == '0);

  p_inc_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_INC) |=> (q == WIDTH'($past(q) + 1)));
  p_dec_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_DEC) |=> (q == WIDTH'($past(q) - 1)));
  p_wrap_up_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_INC && at_top) |=> at_bottom);
  p_wrap_dn_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_DEC && at_bottom) |=> at_top);
endmodule

// File: rtl/updn_cascade_counter.sv
module updn_cascade_counter
  import udc_pkg::*;
#(
  parameter int WIDTH       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             load_n,
  input  logic [WIDTH-1:0] din,
  input  logic             up_strobe,
  input  logic             dn_strobe,
  output logic [WIDTH-1:0] q,
  output logic             carry_n,
  output logic             borrow_n,
  output logic             proto_err
);
  localparam int IDX_UP  = 0;
  localparam int IDX_DN  = 1;
  localparam int N_STROB = 2;

  logic [N_STROB-1:0] strobe_raw, strobe_lvl, strobe_rise;
  logic    up_lvl, dn_lvl, up_rise, dn_rise;
  cnt_op_e op;
  logic    err_evt, at_top, at_bottom;

  assign strobe_raw[IDX_UP] = up_strobe;
  assign strobe_raw[IDX_DN] = dn_strobe;

  for (genvar g = 0; g < N_STROB; g++) begin : g_sync
    udc_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .raw  (strobe_raw[g]),
      .lvl  (strobe_lvl[g]),
      .rise (strobe_rise[g])
    );
  end

  assign up_lvl  = strobe_lvl[IDX_UP];
  assign dn_lvl  = strobe_lvl[IDX_DN];
  assign up_rise = strobe_rise[IDX_UP];
  assign dn_rise = strobe_rise[IDX_DN];

  udc_ctrl u_ctrl (
    .clr    (clr),
    .load_n (load_n),
    .up_lvl (up_lvl),
    .dn_lvl (dn_lvl),
    .up_rise(up_rise),
    .dn_rise(dn_rise),
    .op     (op),
    .err_evt(err_evt)
  );

  udc_core #(.WIDTH(WIDTH)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .op       (op),
    .din      (din),
    .q        (q),
    .at_top   (at_top),
    .at_bottom(at_bottom)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) proto_err <= 1'b0;
    else        proto_err <= err_evt;
  end

  // Gated by the synchronized strobe, so the outputs come only from flops.
  assign carry_n  = ~(at_top & ~up_lvl);
  assign borrow_n = ~(at_bottom & ~dn_lvl);

  p_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (q == '0));
  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !load_n) |=> (q == $past(din)));
  p_carry_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !carry_n |-> (q == '1));
  p_borrow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !borrow_n |-> (q == '0));
  p_err_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |-> (q == $past(q)));
  p_err_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |=> !proto_err);
endmodule

// File: tb/sim_updn_cascade_counter.sv
module sim_updn_cascade_counter;
  localparam int W = 4;

  logic clk = 1'b0;
  logic rst_n, clr, load_n, load_hi_n, up, dn;
  logic [W-1:0] din, din_hi, q0, q1;
  logic carry0, borrow0, err0, carry1, borrow1, err1;

  int checks = 0;
  int errors = 0;
  int errcnt = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  updn_cascade_counter #(.WIDTH(W)) u0 (
    .clk(clk), .rst_n(rst_n), .clr(clr), .load_n(load_n), .din(din),
    .up_strobe(up), .dn_strobe(dn), .q(q0), .carry_n(carry0),
    .borrow_n(borrow0), .proto_err(err0));

  updn_cascade_counter #(.WIDTH(W)) u1 (
    .clk(clk), .rst_n(rst_n), .clr(clr), .load_n(load_hi_n), .din(din_hi),
    .up_strobe(carry0), .dn_strobe(borrow0), .q(q1), .carry_n(carry1),
    .borrow_n(borrow1), .proto_err(err1));

  always @(negedge clk) if (err0) errcnt++;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic preset(input int v);
    din = W'(v); load_n = 1'b0; tick(1); load_n = 1'b1; tick(1);
  endtask

  task automatic pulse_up;
    up = 1'b0; tick(4); up = 1'b1; tick(7);
  endtask

  task automatic pulse_dn;
    dn = 1'b0; tick(4); dn = 1'b1; tick(7);
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; clr = 0; load_n = 1; load_hi_n = 1; up = 1; dn = 1;
    din = '0; din_hi = '0;
    tick(3); rst_n = 1; tick(1);
    // R11 reset state
    check("R11 q", int'(q0), 0);
    check("R11 carry_n", int'(carry0), 1);
    check("R11 borrow_n", int'(borrow0), 1);
    check("R11 proto_err", int'(err0), 0);

    // R2 preset sweep
    for (int v = 0; v < 16; v++) begin
      din = W'(v); load_n = 0; tick(1);
      check("R2 load", int'(q0), v);
    end
    load_n = 1; tick(1);
    // R2 edge during preset is dropped
    din = W'(5); load_n = 0; up = 0; tick(4); up = 1; tick(6);
    load_n = 1; tick(6);
    check("R2 edge dropped", int'(q0), 5);

    // R1 clear overrides preset and strobes
    preset(9);
    clr = 1; load_n = 0; din = W'(3); tick(1);
    check("R1 clear", int'(q0), 0);
    up = 0; tick(4); up = 1; tick(6);
    clr = 0; load_n = 1; tick(6);
    check("R1 clear holds", int'(q0), 0);

    // R3 and R5 up sweep across two wraps
    for (int i = 0; i < 32; i++) begin
      pulse_up;
      check("R3 R5 up", int'(q0), (i + 1) % 16);
    end
    // R4 and R5 down sweep
    preset(0);
    for (int i = 0; i < 32; i++) begin
      pulse_dn;
      check("R4 R5 down", int'(q0), (32 - i - 1) % 16);
    end

    // R9 latency of three clock edges
    preset(7);
    up = 0; tick(4); up = 1; tick(2);
    check("R9 before", int'(q0), 7);
    tick(1);
    check("R9 after", int'(q0), 8);
    tick(5);

    // R6 carry
    preset(15);
    check("R6 carry idle", int'(carry0), 1);
    up = 0; tick(4);
    check("R6 carry low", int'(carry0), 0);
    check("R7 borrow idle at top", int'(borrow0), 1);
    up = 1; tick(7);
    check("R6 carry released", int'(carry0), 1);
    preset(14); up = 0; tick(4);
    check("R6 carry not top", int'(carry0), 1);
    up = 1; tick(7);
    // R7 borrow
    preset(0);
    dn = 0; tick(4);
    check("R7 borrow low", int'(borrow0), 0);
    check("R6 carry idle at zero", int'(carry0), 1);
    dn = 1; tick(7);
    check("R7 borrow released", int'(borrow0), 1);
    check("R7 wrap", int'(q0), 15);

    // R8 edge while other strobe low
    preset(6);
    dn = 0; tick(4); errcnt = 0;
    up = 0; tick(4); up = 1; tick(7);
    check("R8 hold", int'(q0), 6);
    check("R8 one pulse", errcnt, 1);
    dn = 1; tick(7);
    check("R4 after error", int'(q0), 5);
    // R8 both rise together
    up = 0; dn = 0; tick(4); errcnt = 0;
    up = 1; dn = 1; tick(7);
    check("R8 both hold", int'(q0), 5);
    check("R8 both pulse", errcnt, 1);
    // R8 no flag while preset active
    up = 0; dn = 0; tick(4); errcnt = 0; din = W'(2); load_n = 0;
    up = 1; dn = 1; tick(7); load_n = 1; tick(1);
    check("R8 gated by preset", errcnt, 0);

    // R10 cascade
    din = W'(14); din_hi = W'(3); load_n = 0; load_hi_n = 0; tick(1);
    load_n = 1; load_hi_n = 1; tick(6);
    check("R10 preset", int'({q1, q0}), 8'h3E);
    for (int i = 1; i <= 3; i++) begin
      pulse_up;
      check("R10 up", int'({q1, q0}), 8'h3E + i);
    end
    for (int i = 1; i <= 3; i++) begin
      pulse_dn;
      check("R10 down", int'({q1, q0}), 8'h41 - i);
    end
    din = W'(15); din_hi = W'(15); load_n = 0; load_hi_n = 0; tick(1);
    load_n = 1; load_hi_n = 1; tick(6);
    pulse_up;
    check("R10 rollover up", int'({q1, q0}), 8'h00);
    pulse_dn;
    check("R10 rollover down", int'({q1, q0}), 8'hFF);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule